// File: doc/BRIEF.md
# Event Flag Latch and Interrupt Line Aggregator

This block collects event pulses from a bank of channels and one port-level detect signal, holds each as a sticky flag, and turns them into several level-sensitive interrupt lines. Each line has its own enable mask, so different consumers can each watch their own subset of events. A channel pulse sets its flag. The port flag is set when its detect input goes from low to high. Every event also produces a one-cycle routing pulse that a trigger fabric can pick up.

Software reaches the block through a flat word-addressed register port. Address 0 holds the event flags, which can be read and overwritten. Each interrupt line k has two enable addresses. Writing to the set address (2k+1) adds bits to the mask. Writing to the clear address (2k+2) removes bits from it. Reading either address returns the current mask. The interrupt outputs are combinational functions of the stored flags and masks. A line therefore follows any flag or mask change in the same cycle that the stored state changes.

Top module: `evt_irq_agg`

## Requirements
- R1: A write to line k's set address (2k+1) ORs the written bits into that line's mask. A write of zero leaves the mask unchanged.
- R2: A write to line k's clear address (2k+2) removes every written bit from that line's mask and leaves the other bits unchanged.
- R3: A read of either line k's set address or its clear address returns that line's current mask, zero-extended to the data width.
- R4: Interrupt line k is high exactly when some stored flag has its bit set in line k's mask. The line follows a change to a flag or a mask on the first clock edge that stores the change.
- R5: The port flag sits at bit NUM_CH, above the channel bits 0..NUM_CH-1. It is set only when the detect input goes from low to high. A falling edge, or a detect input that stays high, does not set it.
- R6: A pulse on channel i's event input sets flag bit i at the next clock edge. The same edge raises routing output bit i for one cycle. A rising edge on the port detect input does the same for routing bit NUM_CH.
- R7: A write to address 0 replaces the flags with the written bits. Data bits above bit NUM_CH are ignored.
- R8: When a hardware event and a software write that clears the same flag land in the same cycle, the flag ends up set.
- R9: The interrupt lines are independent: a mask write to one line changes neither the mask nor the output of any other line.
- R10: After reset all flags, all masks, all interrupt lines and all routing outputs are zero.
- R11: Writes to addresses above 2*NUM_LINES change no flag and no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_evt_i | input | NUM_CH | One-cycle event pulses, one per channel |
| port_det_i | input | 1 | Port-level detect level; its rising edge is the port event |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address for both writes and reads |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for addr_i |
| irq_o | output | NUM_LINES | Level interrupt lines, one per mask |
| route_o | output | NUM_CH+1 | One-cycle routing pulses; bit NUM_CH is the port event |

## Verification
The hardest case to reach from the ports is a hardware set and a software clear hitting the same flag in the same cycle. The bench drives a channel pulse and a flag-clearing write on the same falling edge, so both reach the same rising edge. The mapping from flags to lines is swept over every flag pattern, paired with several complementary mask pairs on the two lines. For the port flag, the bench holds the detect input high after software clears the flag, to show that a steady level does not set it again.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   // Word address of the event flag register
   localparam int unsigned EVT_ADDR = 0;

   // Address of line k's set-enable register
   function automatic int unsigned set_addr(input int unsigned line);
      return 2 * line + 1;
   endfunction

   // Address of line k's clear-enable register
   function automatic int unsigned clr_addr(input int unsigned line);
      return 2 * line + 2;
   endfunction

   // Number of word addresses in use
   function automatic int unsigned addr_span(input int unsigned lines);
      return 2 * lines + 1;
   endfunction

endpackage

// File: rtl/evt_flag_latch.sv
module evt_flag_latch #(
   parameter int unsigned NUM_CH = 8,
   localparam int unsigned EVT_W = NUM_CH + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_evt_i,
   input  logic              port_det_i,
   input  logic              sw_wr_i,
   input  logic [EVT_W-1:0]  sw_data_i,
   output logic [EVT_W-1:0]  flags_o,
   output logic [EVT_W-1:0]  route_o
);

   logic             det_q;
   logic             port_rise;
   logic [EVT_W-1:0] hw_set;
   logic [EVT_W-1:0] flags_q;
   logic [EVT_W-1:0] flags_d;
   logic [EVT_W-1:0] route_q;

   assign port_rise = port_det_i & ~det_q;
   assign hw_set    = {port_rise, ch_evt_i};

   // hardware set dominates a same-cycle software write
   always_comb begin
      if (sw_wr_i) flags_d = sw_data_i | hw_set;
      else         flags_d = flags_q | hw_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det_q   <= 1'b0;
         flags_q <= '0;
         route_q <= '0;
      end else begin
         det_q   <= port_det_i;
         flags_q <= flags_d;
         route_q <= hw_set;
      end
   end

   assign flags_o = flags_q;
   assign route_o = route_q;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch_chk
         // R6
         ch_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_evt_i[gi] |=> (flags_o[gi] && route_o[gi]));
      end
   endgenerate

   // R5
   port_fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr_i && !flags_o[NUM_CH] && !(port_det_i && !det_q)) |=> !flags_o[NUM_CH]);

   // R8
   hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_i && ch_evt_i[0] && !sw_data_i[0]) |=> flags_o[0]);

endmodule

// File: rtl/en_mask_bank.sv
module en_mask_bank #(
   parameter int unsigned NUM_LINES = 2,
   parameter int unsigned EVT_W     = 9
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_LINES-1:0]             set_wr_i,
   input  logic [NUM_LINES-1:0]             clr_wr_i,
   input  logic [EVT_W-1:0]                 bits_i,
   output logic [NUM_LINES-1:0][EVT_W-1:0]  mask_o
);

   genvar gk;
   generate
      for (gk = 0; gk < NUM_LINES; gk++) begin : g_line
         logic [EVT_W-1:0] mask_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            mask_q <= '0;
            else if (set_wr_i[gk]) mask_q <= mask_q | bits_i;
            else if (clr_wr_i[gk]) mask_q <= mask_q & ~bits_i;
         end

         assign mask_o[gk] = mask_q;

         // R1
         set_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_wr_i[gk] |=> ((mask_o[gk] & $past(bits_i)) == $past(bits_i)));
         // R2
         clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_i[gk] && !set_wr_i[gk]) |=> ((mask_o[gk] & $past(bits_i)) == '0));
         // R9
         idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_wr_i[gk] && !clr_wr_i[gk]) |=> $stable(mask_o[gk]));
      end
   endgenerate

endmodule

// File: rtl/irq_reduce.sv
module irq_reduce #(
   parameter int unsigned NUM_LINES = 2,
   parameter int unsigned EVT_W     = 9,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [EVT_W-1:0]                flags_i,
   input  logic [NUM_LINES-1:0][EVT_W-1:0] mask_i,
   output logic [NUM_LINES-1:0]            irq_o
);

   logic [NUM_LINES-1:0] hit;

   genvar gk;
   generate
      for (gk = 0; gk < NUM_LINES; gk++) begin : g_hit
         assign hit[gk] = |(flags_i & mask_i[gk]);
      end

      if (IRQ_REG) begin : g_reg
         logic [NUM_LINES-1:0] irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= '0;
            else        irq_q <= hit;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign irq_o = hit;
      end
   endgenerate

endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
   import evt_irq_pkg::*;
#(
   parameter int unsigned NUM_CH    = 8,
   parameter int unsigned NUM_LINES = 2,
   parameter int unsigned DATA_W    = 32,
   parameter bit          IRQ_REG   = 1'b0,
   localparam int unsigned EVT_W    = NUM_CH + 1,
   localparam int unsigned ADDR_W   = $clog2(addr_span(NUM_LINES) + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CH-1:0]    ch_evt_i,
   input  logic                 port_det_i,
   input  logic                 wr_en_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rdata_o,
   output logic [NUM_LINES-1:0] irq_o,
   output logic [EVT_W-1:0]     route_o
);

   generate
      if (NUM_CH < 1 || EVT_W > DATA_W) begin : g_bad_width
         $error("evt_irq_agg: NUM_CH must be 1..DATA_W-1");
      end
      if (NUM_LINES < 1) begin : g_bad_lines
         $error("evt_irq_agg: NUM_LINES must be at least 1");
      end
      if (DATA_W > EVT_W) begin : g_hi
         logic unused_wr_hi;
         assign unused_wr_hi = ^wdata_i[DATA_W-1:EVT_W];
      end
   endgenerate

   logic [EVT_W-1:0]                 bits;
   logic                             evt_wr;
   logic [NUM_LINES-1:0]             set_wr;
   logic [NUM_LINES-1:0]             clr_wr;
   logic [EVT_W-1:0]                 flags;
   logic [NUM_LINES-1:0][EVT_W-1:0]  mask;

   assign bits   = wdata_i[EVT_W-1:0];
   assign evt_wr = wr_en_i && (addr_i == ADDR_W'(EVT_ADDR));

   always_comb begin
      set_wr = '0;
      clr_wr = '0;
      for (int k = 0; k < NUM_LINES; k++) begin
         set_wr[k] = wr_en_i && (addr_i == ADDR_W'(set_addr(k)));
         clr_wr[k] = wr_en_i && (addr_i == ADDR_W'(clr_addr(k)));
      end
   end

   evt_flag_latch #(
      .NUM_CH (NUM_CH)
   ) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .ch_evt_i   (ch_evt_i),
      .port_det_i (port_det_i),
      .sw_wr_i    (evt_wr),
      .sw_data_i  (bits),
      .flags_o    (flags),
      .route_o    (route_o)
   );

   en_mask_bank #(
      .NUM_LINES (NUM_LINES),
      .EVT_W     (EVT_W)
   ) u_masks (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_wr_i (set_wr),
      .clr_wr_i (clr_wr),
      .bits_i   (bits),
      .mask_o   (mask)
   );

   irq_reduce #(
      .NUM_LINES (NUM_LINES),
      .EVT_W     (EVT_W),
      .IRQ_REG   (IRQ_REG)
   ) u_reduce (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flags),
      .mask_i  (mask),
      .irq_o   (irq_o)
   );

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(EVT_ADDR)) rdata_o[EVT_W-1:0] = flags;
      for (int k = 0; k < NUM_LINES; k++) begin
         if (addr_i == ADDR_W'(set_addr(k)) || addr_i == ADDR_W'(clr_addr(k)))
            rdata_o[EVT_W-1:0] = mask[k];
      end
   end

   // R4
   no_flag_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && flags == '0) |-> (irq_o == '0));
   // R11
   stray_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && 32'(addr_i) >= addr_span(NUM_LINES)) |=> $stable(mask));

endmodule

// File: tb/evt_irq_agg_tb.sv
`timescale 1ns/1ps
module evt_irq_agg_tb;

   localparam int NCH = 8;
   localparam int NL  = 2;
   localparam int DW  = 32;
   localparam int EW  = NCH + 1;
   localparam int AW  = 3;
   localparam logic [EW-1:0] ALL = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NCH-1:0] ch_evt = '0;
   logic          port_det = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NL-1:0] irq;
   logic [EW-1:0] route;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   evt_irq_agg u_dut (
      .clk(clk), .rst_n(rst_n), .ch_evt_i(ch_evt), .port_det_i(port_det),
      .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .irq_o(irq), .route_o(route)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      addr = AW'(a);
      #0.5;
      d = rdata;
      addr = '0;
   endtask

   function automatic logic [NL-1:0] exp_irq(input logic [EW-1:0] f,
                                             input logic [EW-1:0] m0,
                                             input logic [EW-1:0] m1);
      return {|(f & m1), |(f & m0)};
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [EW-1:0] m0, m1;
      logic [EW-1:0] pats [8];
      pats[0] = 9'h001; pats[1] = 9'h0AA; pats[2] = 9'h155; pats[3] = 9'h100;
      pats[4] = 9'h1FF; pats[5] = 9'h0F0; pats[6] = 9'h000; pats[7] = 9'h10F;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 irq", 32'(irq), 0);
      check("R10 route", 32'(route), 0);
      rd(0, v); check("R10 flags", v, 0);
      rd(1, v); check("R10 mask0", v, 0);
      rd(3, v); check("R10 mask1", v, 0);

      // R1 set ORs bits, zero write no effect
      wr(1, 32'h0000_0011);
      wr(1, 32'h0000_0102);
      rd(1, v); check("R1 set or", v, 32'h113);
      wr(1, 32'h0);
      rd(1, v); check("R1 zero set", v, 32'h113);
      // R3 readback through clear address
      rd(2, v); check("R3 read clr addr", v, 32'h113);
      // R9 other line untouched
      rd(3, v); check("R9 line1 untouched", v, 0);
      // R2 clear removes bits
      wr(2, 32'h0000_0101);
      rd(1, v); check("R2 clr", v, 32'h012);
      wr(2, 32'h0);
      rd(2, v); check("R2 zero clr", v, 32'h012);
      // R7 flag write replaces, upper bits ignored
      wr(0, 32'hFFFF_FE05);
      rd(0, v); check("R7 flag write", v, 32'h005);
      wr(0, 32'h0);
      rd(0, v); check("R7 flag clear", v, 0);

      // R11 stray addresses change nothing
      for (int a = 5; a < 8; a++) begin
         wr(a, 32'hFFFF_FFFF);
         rd(0, v); check("R11 flags", v, 0);
         rd(1, v); check("R11 mask0", v, 32'h012);
         rd(3, v); check("R11 mask1", v, 0);
      end

      // R4 / R9 sweep: every flag pattern against complementary masks
      for (int p = 0; p < 8; p++) begin
         m0 = pats[p]; m1 = ~pats[p];
         wr(2, 32'(ALL)); wr(4, 32'(ALL));
         wr(1, 32'(m0));  wr(3, 32'(m1));
         rd(1, v); check("R3 mask0", v, 32'(m0));
         rd(4, v); check("R3 mask1", v, 32'(m1));
         for (int f = 0; f < 512; f++) begin
            wr(0, 32'(f));
            check("R4 irq sweep", 32'(irq), 32'(exp_irq(EW'(f), m0, m1)));
         end
      end

      // R4 mask change moves line: flags=0x004, line0 mask off then on
      wr(2, 32'(ALL)); wr(4, 32'(ALL));
      wr(0, 32'h004);
      check("R4 masked off", 32'(irq), 0);
      wr(1, 32'h004);
      check("R4 enable raises", 32'(irq), 32'b01);
      wr(2, 32'h004);
      check("R4 disable drops", 32'(irq), 0);
      wr(0, 32'h0);

      // R6 channel pulses and routing
      for (int i = 0; i < NCH; i++) begin
         @(negedge clk); ch_evt = NCH'(1 << i);
         @(negedge clk); ch_evt = '0;
         check("R6 route pulse", 32'(route), 32'(1 << i));
         rd(0, v); check("R6 flag set", v, 32'(1 << i));
         @(negedge clk);
         check("R6 route ends", 32'(route), 0);
         wr(0, 32'h0);
      end

      // R5 port rising edge sets bit 8, routing bit 8
      wr(3, 32'h100);
      @(negedge clk); port_det = 1'b1;
      @(negedge clk);
      check("R5 port route", 32'(route), 32'h100);
      rd(0, v); check("R5 port flag", v, 32'h100);
      check("R5 port irq line1", 32'(irq), 32'b10);
      wr(0, 32'h0);
      repeat (3) @(negedge clk);
      rd(0, v); check("R5 steady high no set", v, 0);
      port_det = 1'b0;
      repeat (3) @(negedge clk);
      rd(0, v); check("R5 falling no set", v, 0);
      check("R5 falling no route", 32'(route), 0);

      // R8 hardware set beats same-cycle clear
      wr(0, 32'h0FF);
      @(negedge clk);
      wr_en = 1'b1; addr = 0; wdata = 32'h0; ch_evt = 8'h08;
      @(negedge clk);
      wr_en = 1'b0; ch_evt = '0;
      rd(0, v); check("R8 hw wins", v, 32'h008);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule